// File: doc/BRIEF.md
# Sized Arithmetic-Logic Unit with Condition Flags

This block is the execute stage of a 16-bit processor. It takes two operands (a destination value and a source value), an operation code, a byte/word size select and the incoming carry. It returns the result at once through combinational logic, together with a write-back enable. It also keeps the four condition flags (overflow V, negative N, zero Z, carry C) in a register. That register is updated on the clock edge at which a valid operation that affects flags is presented.

Twelve two-operand operations combine the destination with the source. Five one-operand operations work on the destination value alone and ignore the source. In byte mode only the low half of each operand takes part, and the result is zero-extended. Byte swap and sign-extend always work on the full word. A condition evaluator reads the registered flags and a 3-bit condition code, and tells the sequencer whether a conditional jump is taken.

Top module: `sized_alu`

## Requirements
- R1: With `byte_mode`=1, only bits 7:0 of both operands are used and bits 15:8 of `result` are 0. The exceptions are byte swap and sign-extend, which always work on 16 bits.
- R2: Opcodes are ADD=1, ADDC=2, SUB=3, SUBC=4. ADD computes dst+src. ADDC computes dst+src+carry_in. SUB computes dst+NOT(src)+1. SUBC computes dst+NOT(src)+carry_in. C is the unsigned carry out of the operand size. V is set when the signed result does not fit that size.
- R3: CMP (5) produces the flags of SUB and BIT (8) produces the flags of AND. For both, `wb_en` is 0.
- R4: DADD (6) adds dst, src and carry_in as packed BCD: four digits in word mode, two in byte mode. The result is the decimal sum in BCD. C is set when the sum exceeds 9999 (99 in byte mode) and V is 0. The operands are assumed to hold valid BCD digits.
- R5: For every flag-affecting operation, N is the top bit of the result at the operand size, and Z is set when all of the result's bits at that size are 0.
- R6: AND (7) computes dst AND src, and BIT (8) computes the same value. Both set C when the result is nonzero and clear V.
- R7: XOR (11) sets C when the result is nonzero, and sets V when the top bits of dst and src at the operand size are both 1.
- R8: RRC (12) shifts dst right by one and puts carry_in into the top bit of the operand size. C takes the old bit 0 and V is 0.
- R9: RRA (13) shifts dst right by one and keeps the top bit. RRU (14) shifts dst right by one and fills the top bit with 0. For both, C takes the old bit 0 and V is 0.
- R10: SWPB (15) exchanges dst bits 15:8 and 7:0. SXT (16) copies dst bit 7 into bits 15:8, sets C when the result is nonzero and clears V.
- R11: MOV (0, result = src), BIC (9, dst AND NOT src), BIS (10, dst OR src) and SWPB write back their result and leave all four flags unchanged.
- R12: Reset clears all flags. The flags change only on a rising clock edge where `op_valid`=1, and then only for a flag-affecting operation. With `op_valid`=0, `wb_en` is 0.
- R13: `jump_take` is computed from the registered flags for each `cond_code`: 0 when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N equals V, 6 when N differs from V, and 7 always.
- R14: Opcodes 17 to 31 give `result`=0 and `wb_en`=0, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | The operation on the inputs is executed this cycle |
| op_code | input | 5 | Operation code |
| byte_mode | input | 1 | 1 = byte operands, 0 = word operands |
| carry_in | input | 1 | Incoming carry for ADDC, SUBC, DADD and RRC |
| dst_in | input | 16 | Destination operand (the single operand for shifts, swap and extend) |
| src_in | input | 16 | Source operand |
| cond_code | input | 3 | Jump condition selector |
| result | output | 16 | Combinational result |
| wb_en | output | 1 | Result is to be written to the destination |
| flag_v | output | 1 | Registered overflow flag |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| jump_take | output | 1 | Selected condition holds on the registered flags |

## Verification
The assertions assume that `op_code`, `byte_mode` and the operands stay steady around each rising edge, so the flags captured at that edge belong to the result seen in the cycle before. The bench changes every input on the falling edge and holds `op_valid` for exactly one clock per operation, so each registered update matches exactly one presented operation. The decimal-add rule holds only for valid BCD digits, and the bench gives that operation only digits 0 to 9.

// File: rtl/salu_pkg.sv
package salu_pkg;

  typedef enum logic [4:0] {
    OP_MOV  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADDC = 5'd2,
    OP_SUB  = 5'd3,
    OP_SUBC = 5'd4,
    OP_CMP  = 5'd5,
    OP_DADD = 5'd6,
    OP_AND  = 5'd7,
    OP_BIT  = 5'd8,
    OP_BIC  = 5'd9,
    OP_BIS  = 5'd10,
    OP_XOR  = 5'd11,
    OP_RRC  = 5'd12,
    OP_RRA  = 5'd13,
    OP_RRU  = 5'd14,
    OP_SWPB = 5'd15,
    OP_SXT  = 5'd16
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_NE, CC_EQ, CC_NC, CC_C, CC_N, CC_GE, CC_LT, CC_ALWAYS
  } cond_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  function automatic logic writes_back(input logic [4:0] op);
    case (op)
      OP_MOV, OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_DADD, OP_AND,
      OP_BIC, OP_BIS, OP_XOR, OP_RRC, OP_RRA, OP_RRU, OP_SWPB, OP_SXT:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic sets_flags(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_DADD, OP_AND, OP_BIT,
      OP_XOR, OP_RRC, OP_RRA, OP_RRU, OP_SXT:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_arith(input logic [4:0] op);
    return (op >= OP_ADD) && (op <= OP_DADD);
  endfunction

  function automatic logic cond_holds(input logic [2:0] cc, input flags_t f);
    case (cc)
      CC_NE:   return !f.z;
      CC_EQ:   return f.z;
      CC_NC:   return !f.c;
      CC_C:    return f.c;
      CC_N:    return f.n;
      CC_GE:   return f.n == f.v;
      CC_LT:   return f.n != f.v;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/salu_arith.sv
module salu_arith
  import salu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [4:0]        op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int HALF_W   = DATA_W / 2;
  localparam int DIGITS   = DATA_W / 4;
  localparam int HALF_DIG = DIGITS / 2;

  // Binary sum with carry out in the top bit.
  function automatic logic [DATA_W:0] bin_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  endfunction

  // Digit-serial BCD sum; top bit is the carry out of digit stop_dig-1.
  function automatic logic [DATA_W:0] dec_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic ci,
                                              input int stop_dig);
    logic [DATA_W-1:0] r;
    logic [4:0]        s;
    logic              cy;
    logic              cy_stop;
    r       = '0;
    cy      = ci;
    cy_stop = 1'b0;
    for (int k = 0; k < DIGITS; k++) begin
      s = {1'b0, a[4*k+:4]} + {1'b0, b[4*k+:4]} + {4'd0, cy};
      if (s > 5'd9) begin
        s  = s - 5'd10;
        cy = 1'b1;
      end else begin
        cy = 1'b0;
      end
      r[4*k+:4] = s[3:0];
      if (k == stop_dig - 1) cy_stop = cy;
    end
    return {cy_stop, r};
  endfunction

  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] opa, opb;
  logic              sub_mode, cin_eff;
  logic [DATA_W:0]   bsum, dsum;
  logic [DATA_W-1:0] bres;
  logic              sa, sb, sr, bcar;

  always_comb begin
    size_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    sub_mode  = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    case (op_i)
      OP_ADDC, OP_SUBC, OP_DADD: cin_eff = carry_i;
      OP_SUB, OP_CMP:            cin_eff = 1'b1;
      default:                   cin_eff = 1'b0;
    endcase
    opa  = dst_i & size_mask;
    opb  = (sub_mode ? ~src_i : src_i) & size_mask;
    bsum = bin_add(opa, opb, cin_eff);
    dsum = dec_add(opa, opb, cin_eff, byte_i ? HALF_DIG : DIGITS);
    bres = bsum[DATA_W-1:0] & size_mask;
    bcar = byte_i ? bsum[HALF_W] : bsum[DATA_W];
    sa   = byte_i ? opa[HALF_W-1]  : opa[DATA_W-1];
    sb   = byte_i ? opb[HALF_W-1]  : opb[DATA_W-1];
    sr   = byte_i ? bres[HALF_W-1] : bres[DATA_W-1];
    if (op_i == OP_DADD) begin
      res_o = dsum[DATA_W-1:0] & size_mask;
      c_o   = dsum[DATA_W];
      v_o   = 1'b0;
    end else begin
      res_o = bres;
      c_o   = bcar;
      v_o   = (sa == sb) && (sr != sa);
    end
  end

endmodule

// File: rtl/salu_logic.sv
module salu_logic
  import salu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [4:0]        op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int HALF_W = DATA_W / 2;

  // Right shift by one at the operand size with a chosen fill bit.
  function automatic logic [DATA_W-1:0] shr1(input logic [DATA_W-1:0] x,
                                             input logic fill,
                                             input logic bsel);
    if (bsel) return {{HALF_W{1'b0}}, fill, x[HALF_W-1:1]};
    return {fill, x[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] size_mask, d, s;
  logic              d_top, s_top;

  always_comb begin
    size_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    d     = dst_i & size_mask;
    s     = src_i & size_mask;
    d_top = byte_i ? d[HALF_W-1] : d[DATA_W-1];
    s_top = byte_i ? s[HALF_W-1] : s[DATA_W-1];
    res_o = '0;
    c_o   = 1'b0;
    v_o   = 1'b0;
    case (op_i)
      OP_MOV: res_o = s;
      OP_AND, OP_BIT: begin
        res_o = d & s;
        c_o   = |res_o;
      end
      OP_BIC: res_o = d & ~s;
      OP_BIS: res_o = d | s;
      OP_XOR: begin
        res_o = d ^ s;
        c_o   = |res_o;
        v_o   = d_top & s_top;
      end
      OP_RRC: begin
        res_o = shr1(d, carry_i, byte_i);
        c_o   = d[0];
      end
      OP_RRA: begin
        res_o = shr1(d, d_top, byte_i);
        c_o   = d[0];
      end
      OP_RRU: begin
        res_o = shr1(d, 1'b0, byte_i);
        c_o   = d[0];
      end
      OP_SWPB: res_o = {dst_i[HALF_W-1:0], dst_i[DATA_W-1:HALF_W]};
      OP_SXT: begin
        res_o = {{HALF_W{dst_i[HALF_W-1]}}, dst_i[HALF_W-1:0]};
        c_o   = |res_o;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/salu_flags.sv
module salu_flags
  import salu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  flags_t     nxt_i,
  input  logic [2:0] cond_i,
  output flags_t     flags_o,
  output logic       take_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flags_o <= '0;
    else if (upd_i) flags_o <= nxt_i;
  end

  assign take_o = cond_holds(cond_i, flags_o);

  a_r12_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_o));

  a_r13_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_ALWAYS) |-> take_o);

  a_r13_ge_lt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_GE) |-> (take_o != cond_holds(CC_LT, flags_o)));

endmodule

// File: rtl/sized_alu.sv
module sized_alu
  import salu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic              byte_mode,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic [2:0]        cond_code,
  output logic [DATA_W-1:0] result,
  output logic              wb_en,
  output logic              flag_v,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              jump_take
);
  localparam int HALF_W = DATA_W / 2;

  logic              word_only, eff_byte, arith_sel;
  logic [DATA_W-1:0] a_res, l_res;
  logic              a_c, a_v, l_c, l_v;
  logic              res_msb, res_zero, flag_upd;
  flags_t            nxt_flags, cur_flags;

  assign word_only = (op_code == OP_SWPB) || (op_code == OP_SXT);
  assign eff_byte  = byte_mode && !word_only;
  assign arith_sel = is_arith(op_code);

  salu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op_code), .byte_i(eff_byte), .carry_i(carry_in),
    .dst_i(dst_in), .src_i(src_in), .res_o(a_res), .c_o(a_c), .v_o(a_v)
  );

  salu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_code), .byte_i(eff_byte), .carry_i(carry_in),
    .dst_i(dst_in), .src_i(src_in), .res_o(l_res), .c_o(l_c), .v_o(l_v)
  );

  assign result   = arith_sel ? a_res : l_res;
  assign wb_en    = op_valid && writes_back(op_code);
  assign res_msb  = eff_byte ? result[HALF_W-1] : result[DATA_W-1];
  assign res_zero = eff_byte ? (result[HALF_W-1:0] == '0) : (result == '0);
  assign flag_upd = op_valid && sets_flags(op_code);

  always_comb begin
    nxt_flags.v = arith_sel ? a_v : l_v;
    nxt_flags.n = res_msb;
    nxt_flags.z = res_zero;
    nxt_flags.c = arith_sel ? a_c : l_c;
  end

  salu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(flag_upd), .nxt_i(nxt_flags),
    .cond_i(cond_code), .flags_o(cur_flags), .take_o(jump_take)
  );

  assign flag_v = cur_flags.v;
  assign flag_n = cur_flags.n;
  assign flag_z = cur_flags.z;
  assign flag_c = cur_flags.c;

  a_r1_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && byte_mode && !word_only) |-> (result[DATA_W-1:HALF_W] == '0));

  a_r3_compare_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP || op_code == OP_BIT) |-> !wb_en);

  a_r5_zero_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sets_flags(op_code) && result == '0) |=> flag_z);

  a_r11_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_MOV || op_code == OP_BIC || op_code == OP_BIS
                  || op_code == OP_SWPB))
    |=> $stable({flag_v, flag_n, flag_z, flag_c}));

  a_r14_unassigned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > OP_SXT) |-> (!wb_en && result == '0));

endmodule

// File: tb/sized_alu_bench.sv
module sized_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic        byte_mode = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] dst_in = '0;
  logic [15:0] src_in = '0;
  logic [2:0]  cond_code = '0;
  logic [15:0] result;
  logic        wb_en, flag_v, flag_n, flag_z, flag_c, jump_take;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sized_alu u_sized_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .carry_in(carry_in), .dst_in(dst_in),
    .src_in(src_in), .cond_code(cond_code), .result(result), .wb_en(wb_en),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .jump_take(jump_take)
  );

  // op, byte, cin, dst, src, expected result, expected wb, expected VNZC
  localparam int NV = 27;
  localparam logic [59:0] VEC [NV] = '{
    {5'd1,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'b1100},
    {5'd1,  1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b0011},
    {5'd1,  1'b1, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 1'b1, 4'b0011},
    {5'd2,  1'b0, 1'b1, 16'h1000, 16'h2000, 16'h3001, 1'b1, 4'b0000},
    {5'd3,  1'b0, 1'b0, 16'h0005, 16'h0007, 16'hFFFE, 1'b1, 4'b0100},
    {5'd3,  1'b0, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 4'b1001},
    {5'd4,  1'b0, 1'b0, 16'h0005, 16'h0003, 16'h0001, 1'b1, 4'b0001},
    {5'd5,  1'b0, 1'b0, 16'h0042, 16'h0042, 16'h0000, 1'b0, 4'b0011},
    {5'd5,  1'b1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 4'b1001},
    {5'd6,  1'b0, 1'b0, 16'h1234, 16'h5678, 16'h6912, 1'b1, 4'b0000},
    {5'd6,  1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 4'b0011},
    {5'd6,  1'b1, 1'b0, 16'hAB45, 16'hCD55, 16'h0000, 1'b1, 4'b0011},
    {5'd6,  1'b1, 1'b0, 16'h0049, 16'h0038, 16'h0087, 1'b1, 4'b0100},
    {5'd7,  1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 4'b0001},
    {5'd7,  1'b1, 1'b0, 16'h12F0, 16'h340F, 16'h0000, 1'b1, 4'b0010},
    {5'd8,  1'b0, 1'b0, 16'h8001, 16'h8000, 16'h8000, 1'b0, 4'b0101},
    {5'd11, 1'b0, 1'b0, 16'h8000, 16'hFFFF, 16'h7FFF, 1'b1, 4'b1001},
    {5'd11, 1'b1, 1'b0, 16'h0055, 16'h0055, 16'h0000, 1'b1, 4'b0010},
    {5'd12, 1'b0, 1'b1, 16'h0002, 16'h0000, 16'h8001, 1'b1, 4'b0100},
    {5'd12, 1'b1, 1'b0, 16'h0003, 16'h0000, 16'h0001, 1'b1, 4'b0001},
    {5'd13, 1'b0, 1'b0, 16'h8003, 16'h0000, 16'hC001, 1'b1, 4'b0101},
    {5'd13, 1'b1, 1'b0, 16'h0081, 16'h0000, 16'h00C0, 1'b1, 4'b0101},
    {5'd14, 1'b0, 1'b0, 16'h8001, 16'h0000, 16'h4000, 1'b1, 4'b0001},
    {5'd16, 1'b0, 1'b0, 16'h0080, 16'h0000, 16'hFF80, 1'b1, 4'b0101},
    {5'd16, 1'b1, 1'b0, 16'h127F, 16'h0000, 16'h007F, 1'b1, 4'b0001},
    {5'd2,  1'b1, 1'b1, 16'h00FF, 16'h0000, 16'h0000, 1'b1, 4'b0011},
    {5'd4,  1'b0, 1'b1, 16'h0003, 16'h0003, 16'h0000, 1'b1, 4'b0011}
  };

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd5, 5'd8:          return "R3";
      5'd6:                return "R4";
      5'd7:                return "R6";
      5'd11:               return "R7";
      5'd12:               return "R8";
      5'd13, 5'd14:        return "R9";
      5'd16:               return "R10";
      default:             return "R2";
    endcase
  endfunction

  function automatic logic want_take(input logic [2:0] cc, input logic [3:0] f);
    logic v, n, z, c;
    {v, n, z, c} = f;
    if (cc == 3'd7) return 1'b1;
    if (cc == 3'd6) return v ^ n;
    if (cc == 3'd5) return ~(v ^ n);
    if (cc == 3'd4) return n;
    if (cc == 3'd3) return c;
    if (cc == 3'd2) return ~c;
    if (cc == 3'd1) return z;
    return ~z;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic bm, input logic ci,
                       input logic [15:0] d, input logic [15:0] s, input logic vld);
    @(negedge clk);
    op_code = op; byte_mode = bm; carry_in = ci;
    dst_in = d; src_in = s; op_valid = vld;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] flags_now();
    return {28'd0, flag_v, flag_n, flag_z, flag_c};
  endfunction

  task automatic jump_sweep(input logic [3:0] f);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cond_code = 3'(k);
      #1;
      chk("R13 jump", {31'd0, jump_take}, {31'd0, want_take(3'(k), f)});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset flags", flags_now(), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [59:0] e;
      string       t;
      e = VEC[i];
      t = e[54] ? {req_of(e[59:55]), " R1"} : req_of(e[59:55]);
      drive(e[59:55], e[54], e[53], e[52:37], e[36:21], 1'b1);
      chk({t, " result"}, {16'd0, result}, {16'd0, e[20:5]});
      chk({t, " wb"}, {31'd0, wb_en}, {31'd0, e[4]});
      settle();
      chk({t, " R5 flags"}, flags_now(), {28'd0, e[3:0]});
    end

    // Known flag pattern VNZC = 1001, then operations that keep flags (R11)
    drive(5'd11, 1'b0, 1'b0, 16'h8000, 16'hFFFF, 1'b1);
    settle();
    drive(5'd0, 1'b0, 1'b0, 16'hFFFF, 16'h1234, 1'b1);
    chk("R11 mov result", {16'd0, result}, 32'h1234);
    chk("R11 mov wb", {31'd0, wb_en}, 32'h1);
    settle();
    chk("R11 mov flags", flags_now(), 32'h9);
    drive(5'd9, 1'b0, 1'b0, 16'hFF0F, 16'h0F0F, 1'b1);
    chk("R11 bic result", {16'd0, result}, 32'hF000);
    settle();
    chk("R11 bic flags", flags_now(), 32'h9);
    drive(5'd10, 1'b1, 1'b0, 16'h1200, 16'h0081, 1'b1);
    chk("R11 R1 bis byte result", {16'd0, result}, 32'h0081);
    settle();
    chk("R11 bis flags", flags_now(), 32'h9);
    drive(5'd15, 1'b1, 1'b0, 16'h12AB, 16'h0000, 1'b1);
    chk("R10 swpb result", {16'd0, result}, 32'hAB12);
    chk("R10 swpb wb", {31'd0, wb_en}, 32'h1);
    settle();
    chk("R11 swpb flags", flags_now(), 32'h9);

    jump_sweep(4'b1001);

    // op_valid low: no flag change, no write-back (R12)
    drive(5'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 1'b0);
    chk("R12 idle wb", {31'd0, wb_en}, 32'h0);
    settle();
    chk("R12 idle flags", flags_now(), 32'h9);

    // Unassigned opcodes (R14)
    drive(5'd31, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    chk("R14 result", {16'd0, result}, 32'h0);
    chk("R14 wb", {31'd0, wb_en}, 32'h0);
    settle();
    chk("R14 flags", flags_now(), 32'h9);
    drive(5'd17, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1);
    chk("R14 wb 17", {31'd0, wb_en}, 32'h0);
    settle();
    chk("R14 flags 17", flags_now(), 32'h9);

    // Equal compare gives Z=1 C=1, then the jump sweep (R3, R13)
    drive(5'd5, 1'b0, 1'b0, 16'h0042, 16'h0042, 1'b1);
    settle();
    chk("R3 cmp flags", flags_now(), 32'h3);
    jump_sweep(4'b0011);

    // Negative less-than pattern N=1 V=0
    drive(5'd3, 1'b0, 1'b0, 16'h0005, 16'h0007, 1'b1);
    settle();
    jump_sweep(4'b0100);

    // Reset again clears the flags (R12)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R12 re-reset flags", flags_now(), 32'h0);
    rst_n = 1'b1;

    finish_run();
  end

endmodule